// File: doc/BRIEF.md
# Receive Message Byte Buffer with Fill and Message Interrupts

This block sits between a bit-level HDLC deframer and a host processor. The deframer pushes de-stuffed payload bytes one at a time. At the end of each frame it signals the end of the message with a 3-bit outcome code. The host pops bytes from the head of the buffer, which holds 159 bytes. The host sees the current byte count at all times. It also sees the length of the most recently finished message, so messages that arrive back to back can be separated in the byte stream.

Two status fields drive a single interrupt line. The first is a live 2-bit fill indication, with a sticky overflow value. The second is a latched 3-bit message outcome. Each field has its own mask. A mode input lets the buffer reaching half capacity also post a message outcome. This serves messages that are longer than the buffer. The host register interface is reduced to a read strobe and a status-clear strobe.

Top module: `msg_fifo_irq`

## Requirements
- R1: After reset, depth, msg_len, fill_stat, msg_stat and irq are all zero.
- R2: depth equals the number of bytes held. It rises by one on an accepted write, falls by one on a read of a non-empty buffer, and is unchanged when both happen in the same cycle.
- R3: rd_data always shows the oldest stored byte, and bytes leave in the order they were written. A rd_en on an empty buffer has no effect.
- R4: On eom, msg_len is loaded with the number of bytes accepted since the previous eom. A write accepted in the same cycle is included. The count then restarts from zero.
- R5: fill_stat is 2'b00 below 80 bytes, 2'b01 at 80 or more, and 2'b10 at 159 bytes. The buffer never holds more than 159 bytes.
- R6: A write while 159 bytes are held is dropped and leaves the stored bytes unchanged. It sets a sticky overflow, which is shown as fill_stat 2'b11 and is cleared only by stat_rd.
- R7: eom latches eom_code into msg_stat, and the value holds until stat_rd clears it. An eom in the same cycle as stat_rd wins.
- R8: With half_mode=1, the write that takes the count from 79 to 80 latches msg_stat=3'b010, unless eom occurs in the same cycle. With half_mode=0, crossing half full leaves msg_stat unchanged.
- R9: irq is high exactly when a msg_stat bit under a set msg_mask bit is 1, or a fill_stat bit under a set fill_mask bit is 1. For example, mask 3'b110 raises irq for 3'b010 and 3'b100 but not for 3'b001. Mask 2'b11 raises irq for any non-zero fill_stat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Deframer byte write strobe |
| wr_data | input | 8 | Byte to store, first received bit in bit 0 |
| eom | input | 1 | End-of-message event |
| eom_code | input | 3 | Message outcome code latched on eom |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest stored byte |
| depth | output | 8 | Bytes currently held |
| msg_len | output | 16 | Byte length of the last finished message |
| stat_rd | input | 1 | Host status read; clears msg_stat and overflow |
| half_mode | input | 1 | 1: reaching half full also latches msg_stat 3'b010 |
| msg_mask | input | 3 | Interrupt enables for msg_stat bits |
| fill_mask | input | 2 | Interrupt enables for fill_stat bits |
| fill_stat | output | 2 | 00 below half, 01 half or more, 10 full, 11 overflowed |
| msg_stat | output | 3 | Latched message status |
| irq | output | 1 | Combined interrupt request |

## Verification
The hold property on msg_stat assumes that half_mode is kept at 0 whenever no eom or stat_rd arrives. The bench keeps to this by raising half_mode only in the half-full directed test, where the property is not required. The overflow and depth-increment properties assume that the host does not pulse rd_en in the same cycle it expects a write to count. The bench never combines rd_en with a write into a full buffer. All inputs change half a clock period away from the sampling edge.

// File: rtl/msg_fifo_irq.sv
module msg_fifo_irq #(
  parameter int DEPTH = 159,
  parameter int DW    = 8,
  parameter int LW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          eom,
  input  logic [2:0]    eom_code,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] depth,
  output logic [LW-1:0] msg_len,
  input  logic          stat_rd,
  input  logic          half_mode,
  input  logic [2:0]    msg_mask,
  input  logic [1:0]    fill_mask,
  output logic [1:0]    fill_stat,
  output logic [2:0]    msg_stat,
  output logic          irq
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'((DEPTH + 1) / 2);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [LW-1:0] mcnt;
  logic          ovf;

  wire           wr_ok  = wr_en && (cnt != FULLV);
  wire           rd_ok  = rd_en && (cnt != '0);
  wire [CW-1:0]  cnt_nx = cnt + CW'(wr_ok) - CW'(rd_ok);
  wire           half_up = (cnt < HALFV) && (cnt_nx >= HALFV);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt    <= '0;
      msg_len <= '0;
    end else if (eom) begin
      msg_len <= mcnt + LW'(wr_ok);
      mcnt    <= '0;
    end else begin
      mcnt    <= mcnt + LW'(wr_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  msg_stat <= 3'b000;
    else if (eom)                msg_stat <= eom_code;
    else if (half_mode && half_up) msg_stat <= 3'b010;
    else if (stat_rd)            msg_stat <= 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf <= 1'b0;
    else if (wr_en && !wr_ok)  ovf <= 1'b1;
    else if (stat_rd)          ovf <= 1'b0;
  end

  assign rd_data   = mem[rp];
  assign depth     = cnt;
  assign fill_stat = ovf            ? 2'b11 :
                     (cnt == FULLV) ? 2'b10 :
                     (cnt >= HALFV) ? 2'b01 : 2'b00;
  assign irq = (|(msg_stat & msg_mask)) | (|(fill_stat & fill_mask));
endmodule

// File: rtl/msg_fifo_irq_chk.sv
module msg_fifo_irq_chk #(
  parameter int DEPTH = 159,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          eom,
  input logic [2:0]    eom_code,
  input logic          stat_rd,
  input logic          half_mode,
  input logic [CW-1:0] depth,
  input logic [1:0]    fill_stat,
  input logic [2:0]    msg_stat
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  a_r2_depth_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && depth != FULLV) |=> depth == $past(depth) + CW'(1));

  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULLV);

  a_r5_full_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_stat == 2'b10) |-> (depth == FULLV));

  a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && depth == FULLV) |=> fill_stat == 2'b11);

  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    eom |=> msg_stat == $past(eom_code));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eom && !stat_rd && !half_mode) |=> $stable(msg_stat));
endmodule

bind msg_fifo_irq msg_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .eom(eom),
  .eom_code(eom_code), .stat_rd(stat_rd), .half_mode(half_mode),
  .depth(depth), .fill_stat(fill_stat), .msg_stat(msg_stat));

// File: tb/sim_msg_fifo_irq.sv
module sim_msg_fifo_irq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, eom = 0, rd_en = 0, stat_rd = 0, half_mode = 0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  eom_code = '0, msg_mask = '0;
  logic [1:0]  fill_mask = '0;
  logic [7:0]  rd_data, depth;
  logic [15:0] msg_len;
  logic [1:0]  fill_stat;
  logic [2:0]  msg_stat;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  msg_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .eom(eom),
    .eom_code(eom_code), .rd_en(rd_en), .rd_data(rd_data), .depth(depth),
    .msg_len(msg_len), .stat_rd(stat_rd), .half_mode(half_mode),
    .msg_mask(msg_mask), .fill_mask(fill_mask), .fill_stat(fill_stat),
    .msg_stat(msg_stat), .irq(irq));

  typedef struct packed {
    logic       wr; logic [7:0] d; logic eom; logic [2:0] code;
    logic       rd; logic srd;
    logic [7:0] xdep; logic [2:0] xst; logic xirq; logic [7:0] xlen;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{1'b1, 8'hA5, 1'b0, 3'd0, 1'b0, 1'b0, 8'd1, 3'b000, 1'b0, 8'd0},
    '{1'b1, 8'h3C, 1'b0, 3'd0, 1'b0, 1'b0, 8'd2, 3'b000, 1'b0, 8'd0},
    '{1'b1, 8'h7E, 1'b1, 3'd1, 1'b0, 1'b0, 8'd3, 3'b001, 1'b0, 8'd3},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'd3, 3'b000, 1'b0, 8'd3},
    '{1'b0, 8'h00, 1'b1, 3'd2, 1'b0, 1'b0, 8'd3, 3'b010, 1'b1, 8'd0},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'd2, 3'b010, 1'b1, 8'd0},
    '{1'b1, 8'h11, 1'b0, 3'd0, 1'b0, 1'b1, 8'd3, 3'b000, 1'b0, 8'd0},
    '{1'b0, 8'h00, 1'b1, 3'd4, 1'b0, 1'b0, 8'd3, 3'b100, 1'b1, 8'd1},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'd2, 3'b100, 1'b1, 8'd1},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 8'd1, 3'b000, 1'b0, 8'd1},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'd0, 3'b000, 1'b0, 8'd1},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'd0, 3'b000, 1'b0, 8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic e,
                      input logic [2:0] c, input logic r, input logic s);
    @(negedge clk);
    wr_en = w; wr_data = d; eom = e; eom_code = c; rd_en = r; stat_rd = s;
    @(posedge clk);
    #1;
    wr_en = 0; eom = 0; rd_en = 0; stat_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 depth", depth, 0);
    chk("R1 msg_len", msg_len, 0);
    chk("R1 fill_stat", fill_stat, 0);
    chk("R1 msg_stat", msg_stat, 0);
    chk("R1 irq", irq, 0);

    // Vector walk: R2 depth, R4 length, R7 latch, R9 mask 110
    msg_mask = 3'b110;
    foreach (VT[i]) begin
      step(VT[i].wr, VT[i].d, VT[i].eom, VT[i].code, VT[i].rd, VT[i].srd);
      chk("R2 depth", depth, VT[i].xdep);
      chk("R7 msg_stat", msg_stat, VT[i].xst);
      chk("R9 irq", irq, VT[i].xirq);
      chk("R4 msg_len", msg_len, VT[i].xlen);
    end

    // R3 order
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 8'(i * 17 + 3), 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      chk("R3 rd_data", rd_data, i * 17 + 3);
      step(0, 0, 0, 0, 1, 0);
    end
    chk("R3 empty depth", depth, 0);

    // R8 half_mode=1
    do_reset();
    half_mode = 1; msg_mask = 3'b010; fill_mask = 2'b00;
    for (int i = 0; i < 79; i++) step(1, 8'(i), 0, 0, 0, 0);
    chk("R5 below half", fill_stat, 0);
    chk("R8 no status yet", msg_stat, 0);
    chk("R9 irq low", irq, 0);
    step(1, 8'd79, 0, 0, 0, 0);
    chk("R5 half", fill_stat, 1);
    chk("R8 half status", msg_stat, 2);
    chk("R9 irq half", irq, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R7 cleared", msg_stat, 0);
    chk("R9 irq cleared", irq, 0);
    half_mode = 0;

    // R8 half_mode=0, R5 full, R6 overflow
    do_reset();
    msg_mask = 3'b000; fill_mask = 2'b11;
    for (int i = 0; i < 80; i++) step(1, 8'(i), 0, 0, 0, 0);
    chk("R8 mode0 no status", msg_stat, 0);
    chk("R9 fill irq", irq, 1);
    for (int i = 80; i < 159; i++) step(1, 8'(i), 0, 0, 0, 0);
    chk("R5 full code", fill_stat, 2);
    chk("R5 full depth", depth, 159);
    step(1, 8'hEE, 1, 3'b001, 0, 0);
    chk("R6 overflow code", fill_stat, 3);
    chk("R6 depth held", depth, 159);
    chk("R4 full msg_len", msg_len, 159);
    chk("R7 eom code", msg_stat, 1);
    chk("R6 head intact", rd_data, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 overflow cleared", fill_stat, 2);
    step(0, 0, 1, 3'b100, 0, 1);
    chk("R7 eom beats clear", msg_stat, 4);

    finish_run();
  end
endmodule